// File: doc/BRIEF.md
# Serializer digital loopback interconnect

This block sits between a bank of audio serializers and their pins and decides where each receiving serializer takes its data from. In normal operation every receiver listens to its own pin. When the self-test loopback is switched on with a legal setting and the frame mode is multi-slot TDM, adjacent serializers are paired. One member of each pair transmits and the other receives the looped data. An ordering bit chooses which member of the pair transmits. The looped path lets the serializer code be checked against itself without any external wiring.

The block also chooses the bit clock and frame sync that the receive section uses. In loopback the receive side is forced onto the transmit clock and frame sync, so both sections run in lockstep. Each transmit pin driver is gated by its per-pin function and direction bits.

All outputs are registered once, off a system clock that oversamples the serial clocks. The looped data therefore has the same one-cycle latency as the pin data. An illegal loopback setting raises a sticky error flag, which software clears by writing 1.

Top module: `ser_lb_xconn`

## Requirements
- R1: With loopback active and `lb_order`=0, each even serializer 2k receives `tx_data[2k+1]` on `rx_data[2k]` one clock later.
- R2: With loopback active and `lb_order`=1, each odd serializer 2k+1 receives `tx_data[2k]` on `rx_data[2k+1]` one clock later.
- R3: Loopback is active only when `lb_en`=1, `lb_mode`=2'b01 and `frame_mode` is a TDM slot count from 2 to 32 inclusive. Any other code (0 for burst, 0x180 for the biphase-mark mode, 1, 33 and above) leaves every receiver on its pin.
- R4: While loopback is active, `rx_bclk_sel`/`rx_fsync_sel` follow `tx_bclk`/`tx_fsync` one clock later, whatever the value of `clk_async`.
- R5: While loopback is inactive, `rx_bclk_sel`/`rx_fsync_sel` follow `rx_bclk_ext`/`rx_fsync_ext` when `clk_async`=1, and follow `tx_bclk`/`tx_fsync` when `clk_async`=0. Both cases have one clock of latency.
- R6: `pin_oe[i]` is 1 one clock later exactly when loopback is active, serializer i is the transmitter of its pair (odd when `lb_order`=0, even when `lb_order`=1), `pin_func[i]`=0 and `pin_dir[i]`=1. When it is 1, `pin_out[i]` equals `tx_data[i]`.
- R7: Whenever `pin_oe[i]` is 0, `pin_out[i]` is 0.
- R8: A receiver fed by the loopback ignores its `pin_in` bit. Every other `rx_data` bit (loopback inactive, or the transmitter of a pair) carries its own `pin_in` bit one clock later.
- R9: `lb_en`=1 with `lb_mode` other than 2'b01 sets `cfg_err` on the next clock and leaves loopback inactive.
- R10: `cfg_err` stays 1 until a cycle with `err_clr`=1 and no new error. A new error in the same cycle as `err_clr` keeps the flag set.
- R11: Synchronous reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_en | input | 1 | Loopback enable |
| lb_order | input | 1 | 0: odd feeds even below; 1: even feeds odd above |
| lb_mode | input | 2 | Loopback clocking mode; only 2'b01 is legal |
| clk_async | input | 1 | 1: receive uses its own clock and frame sync when not looping |
| frame_mode | input | FMODE_W | Transmit frame-mode code (slot count for TDM) |
| err_clr | input | 1 | Write-1 clear of the configuration error |
| tx_data | input | NSER | Serial output bit of each serializer |
| pin_in | input | NSER | Data sampled from each pin |
| pin_func | input | NSER | Per-pin function bit (0 = serial port use) |
| pin_dir | input | NSER | Per-pin direction bit (1 = output) |
| tx_bclk | input | 1 | Transmit bit clock (sampled) |
| tx_fsync | input | 1 | Transmit frame sync |
| rx_bclk_ext | input | 1 | Receive-side bit clock |
| rx_fsync_ext | input | 1 | Receive-side frame sync |
| rx_data | output | NSER | Data delivered to each serializer input |
| pin_out | output | NSER | Pin output data |
| pin_oe | output | NSER | Pin output enable |
| rx_bclk_sel | output | 1 | Bit clock chosen for the receive section |
| rx_fsync_sel | output | 1 | Frame sync chosen for the receive section |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The assertions check the pairing rule for both orderings, the fallback to pins for non-TDM codes, the clock-source choice and the pin gating on every cycle. They also check that an undriven pin reads 0 and that the error flag sets and holds. Only the bench scenarios can show a looped receiver ignoring arbitrary pin activity across many data patterns, and the set-wins-over-clear collision on the error flag. The same holds for the exact boundary codes 1, 2, 32, 33, 0 and 0x180, and for a pin configured as an output that stays dark because its serializer is a receiver.

// File: rtl/ser_lb_pkg.sv
package ser_lb_pkg;
  localparam int FMODE_W   = 9;
  localparam int TDM_MIN   = 2;
  localparam int TDM_MAX   = 32;
  localparam logic [1:0] LB_MODE_SYNC = 2'b01;

  typedef struct packed {
    logic bclk;
    logic fsync;
  } clkfs_t;

  function automatic logic code_is_tdm(input logic [FMODE_W-1:0] code);
    return (code >= FMODE_W'(TDM_MIN)) && (code <= FMODE_W'(TDM_MAX));
  endfunction
endpackage

// File: rtl/ser_lb_ctrl.sv
module ser_lb_ctrl
  import ser_lb_pkg::*;
#(
  parameter int FMODE_W = ser_lb_pkg::FMODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lb_en,
  input  logic [1:0]         lb_mode,
  input  logic [FMODE_W-1:0] frame_mode,
  input  logic               err_clr,
  output logic               lb_active,
  output logic               cfg_err
);
  logic mode_bad;

  assign mode_bad  = lb_en && (lb_mode != LB_MODE_SYNC);
  assign lb_active = lb_en && !mode_bad && code_is_tdm(frame_mode);

  always_ff @(posedge clk) begin
    if (rst)           cfg_err <= 1'b0;
    else if (mode_bad) cfg_err <= 1'b1;
    else if (err_clr)  cfg_err <= 1'b0;
  end
endmodule

// File: rtl/ser_lb_route.sv
module ser_lb_route #(
  parameter int NSER = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lb_active,
  input  logic            lb_order,
  input  logic [NSER-1:0] tx_data,
  input  logic [NSER-1:0] pin_in,
  output logic [NSER-1:0] rx_data
);
  localparam int NPAIR = NSER / 2;

  logic [NSER-1:0] rx_nxt;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int EV = 2 * p;
    localparam int OD = 2 * p + 1;
    always_comb begin
      rx_nxt[EV] = (lb_active && !lb_order) ? tx_data[OD] : pin_in[EV];
      rx_nxt[OD] = (lb_active &&  lb_order) ? tx_data[EV] : pin_in[OD];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_data <= '0;
    else     rx_data <= rx_nxt;
  end
endmodule

// File: rtl/ser_lb_pindrv.sv
module ser_lb_pindrv #(
  parameter int NSER = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lb_active,
  input  logic            lb_order,
  input  logic [NSER-1:0] tx_data,
  input  logic [NSER-1:0] pin_func,
  input  logic [NSER-1:0] pin_dir,
  output logic [NSER-1:0] pin_out,
  output logic [NSER-1:0] pin_oe
);
  logic [NSER-1:0] oe_nxt;

  for (genvar i = 0; i < NSER; i++) begin : g_pin
    localparam bit IS_ODD = (i % 2) == 1;
    logic is_tx;
    assign is_tx     = IS_ODD ? !lb_order : lb_order;
    assign oe_nxt[i] = lb_active && is_tx && !pin_func[i] && pin_dir[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[i]  <= 1'b0;
        pin_out[i] <= 1'b0;
      end else begin
        pin_oe[i]  <= oe_nxt[i];
        pin_out[i] <= oe_nxt[i] && tx_data[i];
      end
    end
  end
endmodule

// File: rtl/ser_lb_clksel.sv
module ser_lb_clksel
  import ser_lb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   lb_active,
  input  logic   clk_async,
  input  clkfs_t tx_src,
  input  clkfs_t rx_src,
  output clkfs_t rx_sel
);
  logic use_tx;

  assign use_tx = lb_active || !clk_async;

  always_ff @(posedge clk) begin
    if (rst) rx_sel <= '0;
    else     rx_sel <= use_tx ? tx_src : rx_src;
  end
endmodule

// File: rtl/ser_lb_xconn.sv
module ser_lb_xconn
  import ser_lb_pkg::*;
#(
  parameter int NSER    = 8,
  parameter int FMODE_W = ser_lb_pkg::FMODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lb_en,
  input  logic               lb_order,
  input  logic [1:0]         lb_mode,
  input  logic               clk_async,
  input  logic [FMODE_W-1:0] frame_mode,
  input  logic               err_clr,
  input  logic [NSER-1:0]    tx_data,
  input  logic [NSER-1:0]    pin_in,
  input  logic [NSER-1:0]    pin_func,
  input  logic [NSER-1:0]    pin_dir,
  input  logic               tx_bclk,
  input  logic               tx_fsync,
  input  logic               rx_bclk_ext,
  input  logic               rx_fsync_ext,
  output logic [NSER-1:0]    rx_data,
  output logic [NSER-1:0]    pin_out,
  output logic [NSER-1:0]    pin_oe,
  output logic               rx_bclk_sel,
  output logic               rx_fsync_sel,
  output logic               cfg_err
);
  logic   lb_active;
  clkfs_t tx_src, rx_src, rx_sel;

  assign tx_src = '{bclk: tx_bclk, fsync: tx_fsync};
  assign rx_src = '{bclk: rx_bclk_ext, fsync: rx_fsync_ext};
  assign rx_bclk_sel  = rx_sel.bclk;
  assign rx_fsync_sel = rx_sel.fsync;

  ser_lb_ctrl #(.FMODE_W(FMODE_W)) u_ctrl (
    .clk(clk), .rst(rst), .lb_en(lb_en), .lb_mode(lb_mode),
    .frame_mode(frame_mode), .err_clr(err_clr),
    .lb_active(lb_active), .cfg_err(cfg_err)
  );

  ser_lb_route #(.NSER(NSER)) u_route (
    .clk(clk), .rst(rst), .lb_active(lb_active), .lb_order(lb_order),
    .tx_data(tx_data), .pin_in(pin_in), .rx_data(rx_data)
  );

  ser_lb_pindrv #(.NSER(NSER)) u_pindrv (
    .clk(clk), .rst(rst), .lb_active(lb_active), .lb_order(lb_order),
    .tx_data(tx_data), .pin_func(pin_func), .pin_dir(pin_dir),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  ser_lb_clksel u_clksel (
    .clk(clk), .rst(rst), .lb_active(lb_active), .clk_async(clk_async),
    .tx_src(tx_src), .rx_src(rx_src), .rx_sel(rx_sel)
  );
endmodule

// File: rtl/ser_lb_xconn_chk.sv
module ser_lb_xconn_chk #(
  parameter int NSER    = 8,
  parameter int FMODE_W = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               lb_en,
  input logic               lb_order,
  input logic [1:0]         lb_mode,
  input logic               clk_async,
  input logic [FMODE_W-1:0] frame_mode,
  input logic               err_clr,
  input logic [NSER-1:0]    tx_data,
  input logic [NSER-1:0]    pin_in,
  input logic [NSER-1:0]    pin_func,
  input logic [NSER-1:0]    pin_dir,
  input logic               tx_bclk,
  input logic               tx_fsync,
  input logic               rx_bclk_ext,
  input logic               rx_fsync_ext,
  input logic [NSER-1:0]    rx_data,
  input logic [NSER-1:0]    pin_out,
  input logic [NSER-1:0]    pin_oe,
  input logic               rx_bclk_sel,
  input logic               rx_fsync_sel,
  input logic               cfg_err
);
  logic legal_on, tdm_ok;
  assign tdm_ok   = (frame_mode >= FMODE_W'(2)) && (frame_mode <= FMODE_W'(32));
  assign legal_on = lb_en && (lb_mode == 2'b01);

  for (genvar p = 0; p < NSER / 2; p++) begin : g_pair_chk
    AST_LOOP_EVEN_RX: assert property (@(posedge clk) disable iff (rst)
      legal_on && tdm_ok && !lb_order |=> rx_data[2*p] == $past(tx_data[2*p+1])); // R1
    AST_LOOP_ODD_RX: assert property (@(posedge clk) disable iff (rst)
      legal_on && tdm_ok && lb_order |=> rx_data[2*p+1] == $past(tx_data[2*p])); // R2
  end

  AST_NON_TDM_PINS: assert property (@(posedge clk) disable iff (rst)
    legal_on && !tdm_ok |=> rx_data == $past(pin_in)); // R3
  AST_LOOP_CLK: assert property (@(posedge clk) disable iff (rst)
    legal_on && tdm_ok |=> rx_bclk_sel == $past(tx_bclk) && rx_fsync_sel == $past(tx_fsync)); // R4
  AST_ASYNC_CLK: assert property (@(posedge clk) disable iff (rst)
    !lb_en && clk_async |=> rx_bclk_sel == $past(rx_bclk_ext) && rx_fsync_sel == $past(rx_fsync_ext)); // R5
  AST_OE_GATED: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pin_oe & $past(pin_func | ~pin_dir)) == '0); // R6
  AST_IDLE_PIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0); // R7
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    lb_en && lb_mode != 2'b01 |=> cfg_err && pin_oe == '0); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    cfg_err && !err_clr |=> cfg_err); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !cfg_err && pin_oe == '0 && rx_data == '0); // R11
endmodule

bind ser_lb_xconn ser_lb_xconn_chk #(.NSER(NSER), .FMODE_W(FMODE_W)) u_chk (
  .clk(clk), .rst(rst), .lb_en(lb_en), .lb_order(lb_order), .lb_mode(lb_mode),
  .clk_async(clk_async), .frame_mode(frame_mode), .err_clr(err_clr),
  .tx_data(tx_data), .pin_in(pin_in), .pin_func(pin_func), .pin_dir(pin_dir),
  .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .rx_bclk_ext(rx_bclk_ext),
  .rx_fsync_ext(rx_fsync_ext), .rx_data(rx_data), .pin_out(pin_out),
  .pin_oe(pin_oe), .rx_bclk_sel(rx_bclk_sel), .rx_fsync_sel(rx_fsync_sel),
  .cfg_err(cfg_err)
);

// File: tb/test_ser_lb_xconn.sv
`timescale 1ns/1ps
module test_ser_lb_xconn;
  localparam int N  = 8;
  localparam int FW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lb_en = 0, lb_order = 0, clk_async = 0, err_clr = 0;
  logic [1:0] lb_mode = 2'b01;
  logic [FW-1:0] frame_mode = 9'd8;
  logic [N-1:0] tx_data = '0, pin_in = '0, pin_func = '0, pin_dir = '0;
  logic tx_bclk = 0, tx_fsync = 0, rx_bclk_ext = 0, rx_fsync_ext = 0;
  logic [N-1:0] rx_data, pin_out, pin_oe;
  logic rx_bclk_sel, rx_fsync_sel, cfg_err;

  int checks = 0;
  int failures = 0;
  logic err_model = 1'b0;

  typedef struct {
    logic [N-1:0] rx, pout, poe;
    logic bclk, fs, err;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  ser_lb_xconn #(.NSER(N), .FMODE_W(FW)) i_ser_lb_xconn (
    .clk(clk), .rst(rst), .lb_en(lb_en), .lb_order(lb_order), .lb_mode(lb_mode),
    .clk_async(clk_async), .frame_mode(frame_mode), .err_clr(err_clr),
    .tx_data(tx_data), .pin_in(pin_in), .pin_func(pin_func), .pin_dir(pin_dir),
    .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .rx_bclk_ext(rx_bclk_ext),
    .rx_fsync_ext(rx_fsync_ext), .rx_data(rx_data), .pin_out(pin_out),
    .pin_oe(pin_oe), .rx_bclk_sel(rx_bclk_sel), .rx_fsync_sel(rx_fsync_sel),
    .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  // Driver: derive the expected outputs from the requirements and queue them.
  task automatic step(input string tag);
    exp_t e;
    logic act, illegal;
    illegal = lb_en && (lb_mode != 2'b01);
    act = lb_en && !illegal && (frame_mode >= 2) && (frame_mode <= 32);
    for (int i = 0; i < N; i++) begin
      logic txr, looped;
      txr    = (i % 2 == 1) ? !lb_order : lb_order;
      looped = act && !txr;
      e.rx[i]  = looped ? tx_data[(i % 2 == 1) ? i - 1 : i + 1] : pin_in[i];
      e.poe[i] = act && txr && !pin_func[i] && pin_dir[i];
      e.pout[i] = e.poe[i] ? tx_data[i] : 1'b0;
    end
    e.bclk = (act || !clk_async) ? tx_bclk  : rx_bclk_ext;
    e.fs   = (act || !clk_async) ? tx_fsync : rx_fsync_ext;
    if (illegal)      err_model = 1'b1;
    else if (err_clr) err_model = 1'b0;
    e.err = err_model;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare just after each edge that consumed a queued stimulus.
  initial forever begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "rx_data", 64'(rx_data), 64'(e.rx));
      chk(e.tag, "pin_oe", 64'(pin_oe), 64'(e.poe));
      chk(e.tag, "pin_out", 64'(pin_out), 64'(e.pout));
      chk(e.tag, "rx_bclk_sel", 64'(rx_bclk_sel), 64'(e.bclk));
      chk(e.tag, "rx_fsync_sel", 64'(rx_fsync_sel), 64'(e.fs));
      chk(e.tag, "cfg_err", 64'(cfg_err), 64'(e.err));
    end
  end

  task automatic randomize_data();
    tx_data = N'($urandom); pin_in = N'($urandom);
    tx_bclk = 1'($urandom); tx_fsync = 1'($urandom);
    rx_bclk_ext = 1'($urandom); rx_fsync_ext = 1'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 got=hang exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tx_data = '1; pin_in = '1; tx_bclk = 1; rx_bclk_ext = 1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "rx_data", 64'(rx_data), 0);
    chk("R11", "pin_oe", 64'(pin_oe), 0);
    chk("R11", "pin_out", 64'(pin_out), 0);
    chk("R11", "rx_bclk_sel", 64'(rx_bclk_sel), 0);
    chk("R11", "cfg_err", 64'(cfg_err), 0);
    rst = 1'b0;

    // R5 / R8: no loopback, both clock sources
    pin_dir = '1;
    for (int k = 0; k < 6; k++) begin
      randomize_data(); clk_async = 1'(k % 2); step("R5");
    end
    for (int k = 0; k < 4; k++) begin randomize_data(); step("R8"); end

    // R1 / R4: loopback, order 0, clk_async=1 still forced to transmit clock
    lb_en = 1; lb_mode = 2'b01; frame_mode = 9'd8; clk_async = 1;
    for (int k = 0; k < 8; k++) begin randomize_data(); step("R1"); end
    for (int k = 0; k < 4; k++) begin randomize_data(); step("R4"); end

    // R2: order 1
    lb_order = 1;
    for (int k = 0; k < 8; k++) begin randomize_data(); step("R2"); end

    // R6 / R7: mixed pin function and direction, including receivers set as outputs
    pin_func = 8'b0011_0101; pin_dir = 8'b1110_1011;
    for (int k = 0; k < 6; k++) begin
      randomize_data(); lb_order = 1'(k % 2); step("R6");
    end
    pin_func = '0; pin_dir = '0;
    for (int k = 0; k < 3; k++) begin randomize_data(); step("R7"); end
    pin_dir = '1;

    // R3: frame-mode boundaries
    lb_order = 0;
    frame_mode = 9'd1;   randomize_data(); step("R3");
    frame_mode = 9'd2;   randomize_data(); step("R3");
    frame_mode = 9'd32;  randomize_data(); step("R3");
    frame_mode = 9'd33;  randomize_data(); step("R3");
    frame_mode = 9'd0;   randomize_data(); step("R3");
    frame_mode = 9'h180; randomize_data(); step("R3");
    frame_mode = 9'd16;

    // R9 / R10: illegal mode, sticky flag, clear, and collision
    lb_mode = 2'b10; randomize_data(); step("R9");
    lb_mode = 2'b00; randomize_data(); step("R9");
    lb_mode = 2'b01; randomize_data(); step("R10");
    randomize_data(); step("R10");
    err_clr = 1; randomize_data(); step("R10");
    err_clr = 0; randomize_data(); step("R10");
    lb_mode = 2'b11; step("R9");
    err_clr = 1; step("R10");
    lb_mode = 2'b01; step("R10");
    err_clr = 0; lb_en = 0; randomize_data(); step("R10");

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule